// File: doc/BRIEF.md
# DRAM address multiplexer with refresh

This block connects a video fetch engine to a bank of eight one-bit-wide dynamic RAM chips that together move one byte per access. A 14-bit fetch address is split into a row half and a column half. Both halves go out over a shared 8-bit multiplexed address bus. The row goes out with an active-low row strobe, then the column with an active-low column strobe. A single strobe pair drives all eight chips.

A static strap selects the geometry of the RAM. With the strap low the halves are 7 bits wide, for 128-row parts. With it high they are 8 bits wide, for 256-row parts.

A single-cycle line-start pulse at the beginning of each scan line triggers a burst of five row-strobe-only refresh cycles. The burst takes its rows from an internal 7-bit counter that never resets between lines. While a burst is pending or running, `busy` stays high and fetch requests are not accepted. The fetch engine holds its request until `busy` falls.

Top module: `dram_addr_mux`

## Requirements
- R1: After reset `ras_n` and `cas_n` are 1, `busy` is 0 and `ma` is 0. The first refresh row after reset is 0.
- R2: When `fetch_req` is sampled high while the block is idle with no refresh pending, the access takes four clocks. Clock 1 presents the row with `ras_n`=0 and `cas_n`=1. Clock 2 presents the column with `ras_n`=0 and `cas_n`=1. Clock 3 keeps the column with both strobes 0. Clock 4 keeps the column with both strobes 1. `busy` is 1 during all four clocks.
- R3: With `strap_wide`=0 the row is {0, addr[6:0]} and the column is {0, addr[13:7]}.
- R4: With `strap_wide`=1 the row is addr[7:0] and the column is {00, addr[13:8]}.
- R5: A refresh burst is five cycles of three clocks each, 15 clocks in all. In each cycle `ras_n` is 0, 0, then 1, and `cas_n` stays 1. `ma` carries the refresh row for the whole cycle, and `busy` is 1 throughout.
- R6: Refresh rows increase by one per cycle modulo 128, and carry on from line to line. `ma[7]` is 0 on every refresh cycle in both strap settings.
- R7: If `line_start` and `fetch_req` arrive in the same idle clock, the refresh goes first. A request held high during the burst is accepted on the first idle clock after it, and its row appears one clock later.
- R8: A `line_start` that arrives during an access is remembered. After clock 4 of the access there is one clock with strobes high and `busy`=1, and then the burst begins.
- R9: A `line_start` that arrives while a burst is running is ignored. No second burst follows, and `busy` falls after the 15 clocks.
- R10: When idle with nothing pending, `ma` is 0 and both strobes are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_wide | input | 1 | Geometry strap: 0 gives 7-bit halves, 1 gives 8-bit halves |
| line_start | input | 1 | Single-clock pulse at scan-line start, triggers a refresh burst |
| fetch_req | input | 1 | Fetch request, held high until accepted |
| fetch_addr | input | 14 | Logical byte address, captured on acceptance |
| ma | output | 8 | Multiplexed row/column address to the RAM |
| ras_n | output | 1 | Active-low row strobe |
| cas_n | output | 1 | Active-low column strobe |
| busy | output | 1 | High while an access or refresh runs or a refresh is pending |

## Verification
The assertions take three things for granted about the inputs. The strap is static while the block is active. `line_start` is a one-clock pulse. Reset is applied from time zero. Under those conditions they check that the column strobe only falls inside a row strobe on a stable column address, and that refresh cycles never drop CAS or set the top address bit.

The stimulus keeps within these conditions. It changes `strap_wide` only between scenarios, once `busy` has dropped. It drives `line_start` for exactly one clock. It raises `fetch_req` only when the block is idle or is expected to hold it off. All inputs are driven on the falling clock edge.

// File: rtl/dram_mux_pkg.sv
package dram_mux_pkg;

    parameter int ADDR_W    = 14;  // logical fetch address
    parameter int MA_W      = 8;   // multiplexed pin bus, wide half
    parameter int NARROW_W  = 7;   // half width for 128-row parts
    parameter int REF_W     = 7;   // refresh row counter width
    parameter int REF_BURST = 5;   // refresh cycles per scan line

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_A_ROW,
        ST_A_COL,
        ST_A_CAS,
        ST_A_END,
        ST_R_ROW,
        ST_R_HOLD,
        ST_R_PRE
    } seq_st_e;

    // strobe and address-select controls produced by the sequencer
    typedef struct packed {
        logic drive;    // bus carries an address (else zero)
        logic sel_ref;  // bus carries the refresh row
        logic sel_col;  // bus carries the column half
        logic ras_n;
        logic cas_n;
    } strobe_t;

    function automatic logic [MA_W-1:0] row_half(input logic [ADDR_W-1:0] a, input logic wide);
        logic [MA_W-1:0] r;
        if (wide) r = a[MA_W-1:0];
        else      r = MA_W'(a[NARROW_W-1:0]);
        return r;
    endfunction

    function automatic logic [MA_W-1:0] col_half(input logic [ADDR_W-1:0] a, input logic wide);
        logic [MA_W-1:0] c;
        if (wide) c = MA_W'(a[ADDR_W-1:MA_W]);
        else      c = MA_W'(a[ADDR_W-1:NARROW_W]);
        return c;
    endfunction

    function automatic logic is_access(input seq_st_e s);
        return (s == ST_A_ROW) || (s == ST_A_COL) || (s == ST_A_CAS) || (s == ST_A_END);
    endfunction

    function automatic logic is_refresh(input seq_st_e s);
        return (s == ST_R_ROW) || (s == ST_R_HOLD) || (s == ST_R_PRE);
    endfunction

endpackage

// File: rtl/dram_refresh_ctr.sv
module dram_refresh_ctr
    import dram_mux_pkg::*;
#(
    parameter int ROW_W = REF_W,
    parameter int BURST = REF_BURST
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,   // burst begins
    input  logic             step,    // one refresh cycle completed
    output logic [ROW_W-1:0] row,
    output logic             last
);
    localparam int IDX_W = (BURST > 1) ? $clog2(BURST) : 1;

    logic [ROW_W-1:0] row_q;
    logic [IDX_W-1:0] idx_q;

    // row counter: cleared by reset only, wraps at its own width
    always_ff @(posedge clk) begin
        if (rst)       row_q <= '0;
        else if (step) row_q <= row_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || start) idx_q <= '0;
        else if (step)    idx_q <= idx_q + 1'b1;
    end

    assign row  = row_q;
    assign last = (idx_q == IDX_W'(BURST - 1));

endmodule

// File: rtl/dram_strobe_seq.sv
module dram_strobe_seq
    import dram_mux_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    line_start,
    input  logic    req,
    input  logic    ref_last,
    output logic    latch_en,
    output logic    ref_start,
    output logic    ref_step,
    output logic    busy,
    output logic    in_ref,
    output strobe_t stb
);
    seq_st_e st_q, st_d;
    logic    pend_q, pend_d;

    always_comb begin
        st_d      = st_q;
        pend_d    = pend_q;
        latch_en  = 1'b0;
        ref_start = 1'b0;
        ref_step  = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (line_start || pend_q) begin
                    st_d      = ST_R_ROW;
                    ref_start = 1'b1;
                    pend_d    = 1'b0;
                end else if (req) begin
                    st_d     = ST_A_ROW;
                    latch_en = 1'b1;
                end
            end
            ST_A_ROW:  st_d = ST_A_COL;
            ST_A_COL:  st_d = ST_A_CAS;
            ST_A_CAS:  st_d = ST_A_END;
            ST_A_END:  st_d = ST_IDLE;
            ST_R_ROW:  st_d = ST_R_HOLD;
            ST_R_HOLD: st_d = ST_R_PRE;
            ST_R_PRE: begin
                ref_step = 1'b1;
                st_d     = ref_last ? ST_IDLE : ST_R_ROW;
            end
            default:   st_d = ST_IDLE;
        endcase
        // a line start that lands inside an access waits for it to finish
        if (is_access(st_q) && line_start) pend_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            pend_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            pend_q <= pend_d;
        end
    end

    always_comb begin
        stb = '{drive: 1'b0, sel_ref: 1'b0, sel_col: 1'b0, ras_n: 1'b1, cas_n: 1'b1};
        unique case (st_q)
            ST_A_ROW:  stb = '{drive: 1'b1, sel_ref: 1'b0, sel_col: 1'b0, ras_n: 1'b0, cas_n: 1'b1};
            ST_A_COL:  stb = '{drive: 1'b1, sel_ref: 1'b0, sel_col: 1'b1, ras_n: 1'b0, cas_n: 1'b1};
            ST_A_CAS:  stb = '{drive: 1'b1, sel_ref: 1'b0, sel_col: 1'b1, ras_n: 1'b0, cas_n: 1'b0};
            ST_A_END:  stb = '{drive: 1'b1, sel_ref: 1'b0, sel_col: 1'b1, ras_n: 1'b1, cas_n: 1'b1};
            ST_R_ROW,
            ST_R_HOLD: stb = '{drive: 1'b1, sel_ref: 1'b1, sel_col: 1'b0, ras_n: 1'b0, cas_n: 1'b1};
            ST_R_PRE:  stb = '{drive: 1'b1, sel_ref: 1'b1, sel_col: 1'b0, ras_n: 1'b1, cas_n: 1'b1};
            default:   ;
        endcase
    end

    assign busy   = (st_q != ST_IDLE) || pend_q;
    assign in_ref = is_refresh(st_q);

endmodule

// File: rtl/dram_addr_sel.sv
module dram_addr_sel
    import dram_mux_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int MW = MA_W,
    parameter int RW = REF_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wide,
    input  logic          latch_en,
    input  logic [AW-1:0] addr,
    input  logic [RW-1:0] ref_row,
    input  strobe_t       stb,
    output logic [MW-1:0] ma
);
    logic [AW-1:0] addr_q;
    logic [MW-1:0] ref_bus;

    always_ff @(posedge clk) begin
        if (rst)           addr_q <= '0;
        else if (latch_en) addr_q <= addr;
    end

    // refresh row onto the bus; upper bits stay low in either geometry
    generate
        if (MW > RW) begin : g_pad
            assign ref_bus = {{(MW-RW){1'b0}}, ref_row};
        end else begin : g_trim
            assign ref_bus = ref_row[MW-1:0];
        end
    endgenerate

    always_comb begin
        if (!stb.drive)       ma = '0;
        else if (stb.sel_ref) ma = ref_bus;
        else if (stb.sel_col) ma = col_half(addr_q, wide);
        else                  ma = row_half(addr_q, wide);
    end

endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux
    import dram_mux_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              strap_wide,
    input  logic              line_start,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic [MA_W-1:0]   ma,
    output logic              ras_n,
    output logic              cas_n,
    output logic              busy
);
    logic             latch_en, ref_start, ref_step, ref_last, ref_active;
    logic [REF_W-1:0] ref_row;
    strobe_t          stb;

    dram_strobe_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .line_start(line_start),
        .req       (fetch_req),
        .ref_last  (ref_last),
        .latch_en  (latch_en),
        .ref_start (ref_start),
        .ref_step  (ref_step),
        .busy      (busy),
        .in_ref    (ref_active),
        .stb       (stb)
    );

    dram_refresh_ctr #(.ROW_W(REF_W), .BURST(REF_BURST)) u_ref (
        .clk  (clk),
        .rst  (rst),
        .start(ref_start),
        .step (ref_step),
        .row  (ref_row),
        .last (ref_last)
    );

    dram_addr_sel #(.AW(ADDR_W), .MW(MA_W), .RW(REF_W)) u_sel (
        .clk     (clk),
        .rst     (rst),
        .wide    (strap_wide),
        .latch_en(latch_en),
        .addr    (fetch_addr),
        .ref_row (ref_row),
        .stb     (stb),
        .ma      (ma)
    );

    assign ras_n = stb.ras_n;
    assign cas_n = stb.cas_n;

endmodule

// File: rtl/dram_addr_mux_chk.sv
module dram_addr_mux_chk #(
    parameter int MW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic [MW-1:0] ma,
    input logic          ras_n,
    input logic          cas_n,
    input logic          busy,
    input logic          in_ref
);
    AST_CAS_INSIDE_RAS: assert property (@(posedge clk) disable iff (rst)
        !cas_n |-> !ras_n);                                            // R2
    AST_CAS_COL_STABLE: assert property (@(posedge clk) disable iff (rst)
        $fell(cas_n) |-> $stable(ma));                                 // R2
    AST_STROBES_RISE_TOGETHER: assert property (@(posedge clk) disable iff (rst)
        $rose(cas_n) |-> $rose(ras_n));                                // R2
    AST_ROW_BEFORE_COL: assert property (@(posedge clk) disable iff (rst)
        ($fell(ras_n) && !in_ref) |-> cas_n);                          // R2
    AST_REF_NO_CAS: assert property (@(posedge clk) disable iff (rst)
        in_ref |-> (cas_n && busy));                                   // R5
    AST_REF_MSB_LOW: assert property (@(posedge clk) disable iff (rst)
        in_ref |-> !ma[MW-1]);                                         // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (ras_n && cas_n && ma == '0));                       // R10
endmodule

bind dram_addr_mux dram_addr_mux_chk #(.MW(dram_mux_pkg::MA_W)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .ma    (ma),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .busy  (busy),
    .in_ref(ref_active)
);

// File: tb/sim_dram_addr_mux.sv
module sim_dram_addr_mux;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        strap_wide = 1'b0;
    logic        line_start = 1'b0;
    logic        fetch_req = 1'b0;
    logic [13:0] fetch_addr = '0;
    logic [7:0]  ma;
    logic        ras_n, cas_n, busy;

    int n_cmp = 0;
    int n_bad = 0;
    int ref_exp = 0;   // next refresh row the bench expects
    bit finished = 1'b0;

    always #5 clk = ~clk;

    dram_addr_mux u0 (
        .clk(clk), .rst(rst), .strap_wide(strap_wide), .line_start(line_start),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .ma(ma), .ras_n(ras_n), .cas_n(cas_n), .busy(busy)
    );

    task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [7:0] erow(input logic [13:0] a, input logic w);
        return w ? a[7:0] : {1'b0, a[6:0]};
    endfunction

    function automatic logic [7:0] ecol(input logic [13:0] a, input logic w);
        return w ? {2'b00, a[13:8]} : {1'b0, a[13:7]};
    endfunction

    // Called on the negedge where the first refresh clock is visible.
    // Leaves off on the negedge after the last of the 15 clocks.
    task automatic run_burst(input string rq, input int pulse_at);
        for (int k = 0; k < 15; k++) begin
            chk(rq, "ref ras_n", ras_n, (k % 3 == 2));
            chk(rq, "ref cas_n", cas_n, 1'b1);
            chk(rq, "ref busy", busy, 1'b1);
            chk("R6", "ref row", ma, ref_exp[7:0]);
            if (k == pulse_at) line_start = 1'b1;
            @(negedge clk);
            line_start = 1'b0;
            if (k % 3 == 2) ref_exp = (ref_exp + 1) % 128;
        end
    endtask

    // R2 / R3 / R4: full access at idle
    task automatic t_access(input logic [13:0] a, input logic w, input string rq);
        strap_wide = w;
        @(negedge clk);
        fetch_addr = a; fetch_req = 1'b1;
        @(negedge clk);
        fetch_req = 1'b0;
        chk("R2", "clk1 ras_n", ras_n, 1'b0); chk("R2", "clk1 cas_n", cas_n, 1'b1);
        chk(rq, "row", ma, erow(a, w));       chk("R2", "busy", busy, 1'b1);
        @(negedge clk);
        chk("R2", "clk2 ras_n", ras_n, 1'b0); chk("R2", "clk2 cas_n", cas_n, 1'b1);
        chk(rq, "col", ma, ecol(a, w));
        @(negedge clk);
        chk("R2", "clk3 ras_n", ras_n, 1'b0); chk("R2", "clk3 cas_n", cas_n, 1'b0);
        chk(rq, "col held", ma, ecol(a, w));
        @(negedge clk);
        chk("R2", "clk4 ras_n", ras_n, 1'b1); chk("R2", "clk4 cas_n", cas_n, 1'b1);
        chk("R2", "clk4 busy", busy, 1'b1);
        @(negedge clk);
        chk("R10", "idle busy", busy, 1'b0); chk("R10", "idle ma", ma, 8'h00);
    endtask

    // R5 / R6: one line's burst
    task automatic t_refresh(input logic w);
        strap_wide = w;
        @(negedge clk);
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        run_burst("R5", -1);
        chk("R5", "busy after burst", busy, 1'b0);
        chk("R5", "ras_n after burst", ras_n, 1'b1);
    endtask

    // R7: simultaneous start, request held off
    task automatic t_arbitrate(input logic [13:0] a);
        strap_wide = 1'b0;
        @(negedge clk);
        line_start = 1'b1; fetch_req = 1'b1; fetch_addr = a;
        @(negedge clk);
        line_start = 1'b0;
        chk("R7", "refresh first (cas_n)", cas_n, 1'b1);
        run_burst("R7", -1);
        chk("R7", "idle gap busy", busy, 1'b0);
        chk("R7", "idle gap ras_n", ras_n, 1'b1);
        @(negedge clk);
        fetch_req = 1'b0;
        chk("R7", "held req ras_n", ras_n, 1'b0);
        chk("R7", "held req row", ma, erow(a, 1'b0));
        repeat (4) @(negedge clk);
        chk("R7", "back to idle", busy, 1'b0);
    endtask

    // R8: line start during an access
    task automatic t_pending(input logic [13:0] a);
        strap_wide = 1'b1;
        @(negedge clk);
        fetch_addr = a; fetch_req = 1'b1;
        @(negedge clk);
        fetch_req = 1'b0; line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        chk("R8", "access continues col", ma, ecol(a, 1'b1));
        @(negedge clk);
        chk("R8", "access cas_n", cas_n, 1'b0);
        @(negedge clk);
        chk("R8", "access end ras_n", ras_n, 1'b1);
        @(negedge clk);
        chk("R8", "pending busy", busy, 1'b1);
        chk("R8", "pending ras_n", ras_n, 1'b1);
        @(negedge clk);
        run_burst("R8", -1);
        chk("R8", "busy after burst", busy, 1'b0);
    endtask

    // R9: line start inside a burst is dropped
    task automatic t_ignore();
        strap_wide = 1'b0;
        @(negedge clk);
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        run_burst("R9", 4);
        chk("R9", "busy after burst", busy, 1'b0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R9", "no second burst ras_n", ras_n, 1'b1);
            chk("R9", "no second burst busy", busy, 1'b0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1", "ras_n", ras_n, 1'b1);
        chk("R1", "cas_n", cas_n, 1'b1);
        chk("R1", "busy", busy, 1'b0);
        chk("R1", "ma", ma, 8'h00);
        t_refresh(1'b0);                 // R1: first row 0
        t_access(14'h2A5C, 1'b0, "R3");
        t_access(14'h3FFF, 1'b0, "R3");
        t_access(14'h0080, 1'b0, "R3");
        t_access(14'h2A5C, 1'b1, "R4");
        t_access(14'h3F00, 1'b1, "R4");
        t_access(14'h00FF, 1'b1, "R4");
        t_refresh(1'b1);                 // R6: wide mode keeps bit 7 low
        t_arbitrate(14'h1357);
        t_pending(14'h2BCD);
        t_ignore();
        // R6: run lines until the counter wraps past 127
        for (int l = 0; l < 26; l++) t_refresh(l[0]);
        t_access(14'h1111, 1'b0, "R3");
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule